// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns 32 general-purpose input pins into interrupt requests. Every pin carries its own 4-bit sense setting. The setting picks one of five detection modes (rising edge, falling edge, high level, low level or both edges) and has a flag that selects the short-latency detection path. A detected event is captured only while that pin's acceptance bit is on. Captured events stay in a pending register until software clears them by writing ones. A per-pin enable mask decides which pending bits reach the two interrupt outputs. One output serves pins 0 to 15 and the other serves pins 16 to 31.

Software talks to the block over a simple word-addressed register port. A write happens in any cycle where the write strobe is high. Read data is a combinational function of the address. The pin inputs are asynchronous, so they pass through a synchronizer chain before detection. To change a pin's sense type safely, software turns acceptance off, rewrites the sense field, clears the pin's pending bit and then turns acceptance back on. In the interrupt handler, software reads the masked status, services the lowest set bit first and repeats until the register reads zero.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, the mask, acceptance, pending and all four sense registers read 0, and both interrupt outputs are low.
- R2: The sense registers sit at word addresses 8 to 11 and are read/write. Pin n uses bits [4*(n%8)+3 : 4*(n%8)] of address 8+n/8. Each pin's detection follows its own field and no other.
- R3: Sense bits [2:0] select the mode: 0 rising edge, 1 falling edge, 2 high level, 3 low level, 4 both edges. Codes 5, 6 and 7 never produce an event.
- R4: A write to address 0 sets the mask bits where the data has ones. A write to address 1 clears the mask bits where the data has ones. Zero bits leave the mask unchanged. Both addresses read back the mask.
- R5: A write to address 3 clears the pending bits where the data has ones and leaves the others unchanged. If a level event is active in the same cycle, that bit is set again at once. Address 3 reads the pending register whatever the mask holds.
- R6: Address 2 is the acceptance register (read/write). An event on a pin whose acceptance bit is 0 is dropped, and it is not captured later when acceptance is turned on.
- R7: Address 4 reads the pending register ANDed with the mask.
- R8: Address 5 reads pending bits 15:0 and address 6 reads pending bits 31:16, each placed in bits 15:0 with zeros above.
- R9: irq_lo is the OR of the masked pending bits 0 to 15. irq_hi is the OR of the masked pending bits 16 to 31.
- R10: Suppose an input change is first sampled at clock edge k. With sense bit 3 set, the pending bit is set by edge k+1. With sense bit 3 clear, it is set by edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 32 | Asynchronous pin levels to watch |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lo | output | 1 | Interrupt request for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
The bench clears a pending bit while a low-level pin stays active. A design that lets the clear win over the new event would report an empty pending register there. It raises a pin with acceptance off and then turns acceptance on. A design that remembers the edge, or that samples acceptance late, would show a spurious pending bit. Two pins toggle together, one on the fast path and one on the slow path, and the bench reads pending on every cycle, so an extra or missing synchronizer stage shows up as a one-cycle shift. Reserved sense codes, a sense field written into the neighbouring nibble, and a masked bit leaking onto the wrong interrupt half all show up as wrong pending or status words.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int SENSE_W    = 4;
    localparam int FIELDS_PER = DATA_W / SENSE_W;

    localparam logic [ADDR_W-1:0] ADR_MASK_SET = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_ACCEPT   = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_PEND     = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_MSTAT    = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_RAW_LO   = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_RAW_HI   = 4'd6;
    localparam int                ADR_SENSE0   = 8;

    typedef enum logic [2:0] {
        SNS_RISE = 3'd0,
        SNS_FALL = 3'd1,
        SNS_HIGH = 3'd2,
        SNS_LOW  = 3'd3,
        SNS_BOTH = 3'd4
    } sense_mode_e;

    typedef struct packed {
        logic       fast;   // take the short synchronizer tap
        logic [2:0] mode;
    } sense_t;

    function automatic logic sense_hit(sense_t s, logic cur, logic prev);
        case (sense_mode_e'(s.mode))
            SNS_RISE: return cur & ~prev;
            SNS_FALL: return ~cur & prev;
            SNS_HIGH: return cur;
            SNS_LOW:  return ~cur;
            SNS_BOTH: return cur ^ prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] fast_cur,
    output logic [WIDTH-1:0] fast_prev,
    output logic [WIDTH-1:0] slow_cur,
    output logic [WIDTH-1:0] slow_prev
);
    logic [WIDTH-1:0] chain [0:STAGES];

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign fast_cur  = chain[0];
    assign fast_prev = chain[1];
    assign slow_cur  = chain[STAGES-1];
    assign slow_prev = chain[STAGES];

endmodule

// File: rtl/pic_detect.sv
module pic_detect
    import pic_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sense_t [NUM_PINS-1:0]   sense,
    input  logic   [NUM_PINS-1:0]   fast_cur,
    input  logic   [NUM_PINS-1:0]   fast_prev,
    input  logic   [NUM_PINS-1:0]   slow_cur,
    input  logic   [NUM_PINS-1:0]   slow_prev,
    output logic   [NUM_PINS-1:0]   evt
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic cur, prev;
        assign cur    = sense[p].fast ? fast_cur[p]  : slow_cur[p];
        assign prev   = sense[p].fast ? fast_prev[p] : slow_prev[p];
        assign evt[p] = sense_hit(sense[p], cur, prev);

        AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
            (sense[p].mode > 3'd4) |-> !evt[p]); // R3
    end

endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [NUM_PINS-1:0]   evt,
    output sense_t [NUM_PINS-1:0] sense,
    output logic [NUM_PINS-1:0]   mask,
    output logic [NUM_PINS-1:0]   pending
);
    localparam int NUM_SREG = NUM_PINS / FIELDS_PER;
    localparam int HALF     = NUM_PINS / 2;

    logic [DATA_W-1:0]   sense_q [NUM_SREG];
    logic [NUM_PINS-1:0] mask_q, accept_q, pend_q, pclr;

    assign pclr = (wr_en && addr == ADR_PEND) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            accept_q <= '0;
            pend_q   <= '0;
        end else begin
            if (wr_en && addr == ADR_MASK_SET)      mask_q <= mask_q | wdata;
            else if (wr_en && addr == ADR_MASK_CLR) mask_q <= mask_q & ~wdata;
            if (wr_en && addr == ADR_ACCEPT)        accept_q <= wdata;
            pend_q <= (pend_q & ~pclr) | (evt & accept_q);
        end
    end

    for (genvar k = 0; k < NUM_SREG; k++) begin : g_sreg
        always_ff @(posedge clk) begin
            if (rst) sense_q[k] <= '0;
            else if (wr_en && addr == ADDR_W'(ADR_SENSE0 + k)) sense_q[k] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
        assign sense[p] = sense_t'(sense_q[p / FIELDS_PER][SENSE_W*(p % FIELDS_PER) +: SENSE_W]);
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_MASK_SET, ADR_MASK_CLR: rdata = mask_q;
            ADR_ACCEPT:                 rdata = accept_q;
            ADR_PEND:                   rdata = pend_q;
            ADR_MSTAT:                  rdata = pend_q & mask_q;
            ADR_RAW_LO:                 rdata = {{(DATA_W-HALF){1'b0}}, pend_q[HALF-1:0]};
            ADR_RAW_HI:                 rdata = {{(DATA_W-HALF){1'b0}}, pend_q[NUM_PINS-1:HALF]};
            default: begin
                for (int k = 0; k < NUM_SREG; k++)
                    if (addr == ADDR_W'(ADR_SENSE0 + k)) rdata = sense_q[k];
            end
        endcase
    end

    assign mask    = mask_q;
    assign pending = pend_q;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0 && accept_q == '0 && pend_q == '0)); // R1
    AST_NEW_PEND_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q)) & ~$past(accept_q)) == '0); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_PEND) |=> ((pend_q & $past(wdata & ~(evt & accept_q))) == '0)); // R5
    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_MASK_SET) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R4
    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_MASK_CLR) |=> ((mask_q & $past(wdata)) == '0)); // R4

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_lo,
    output logic                irq_hi
);
    localparam int HALF = NUM_PINS / 2;

    logic [NUM_PINS-1:0]   fast_cur, fast_prev, slow_cur, slow_prev;
    logic [NUM_PINS-1:0]   evt, mask, pending, mstat;
    sense_t [NUM_PINS-1:0] sense;

    pic_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pins_in),
        .fast_cur(fast_cur), .fast_prev(fast_prev),
        .slow_cur(slow_cur), .slow_prev(slow_prev)
    );

    pic_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .sense(sense),
        .fast_cur(fast_cur), .fast_prev(fast_prev),
        .slow_cur(slow_cur), .slow_prev(slow_prev),
        .evt(evt)
    );

    pic_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .evt(evt),
        .sense(sense), .mask(mask), .pending(pending)
    );

    assign mstat  = pending & mask;
    assign irq_lo = |mstat[HALF-1:0];
    assign irq_hi = |mstat[NUM_PINS-1:HALF];

endmodule

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_lo, irq_hi;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_ctrl u_pin_irq_ctrl (
        .clk(clk), .rst(rst), .pins_in(pins), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        pins = '0; wr = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        do_reset();
        bus_read(4'd0, v); check("R1 mask", v, 32'h0);
        bus_read(4'd2, v); check("R1 accept", v, 32'h0);
        bus_read(4'd3, v); check("R1 pending", v, 32'h0);
        for (int k = 8; k < 12; k++) begin
            bus_read(4'(k), v); check("R1 sense", v, 32'h0);
        end
        check("R1 irq", {30'b0, irq_hi, irq_lo}, 32'h0);
    endtask

    task automatic test_layout();
        logic [31:0] v;
        do_reset();
        bus_write(4'd8,  32'h7654_3210);
        bus_write(4'd9,  32'h00A0_0000);
        bus_write(4'd10, 32'h1357_2468);
        bus_write(4'd11, 32'hCAFE_0123);
        bus_read(4'd8,  v); check("R2 sense0", v, 32'h7654_3210);
        bus_read(4'd9,  v); check("R2 sense1", v, 32'h00A0_0000);
        bus_read(4'd10, v); check("R2 sense2", v, 32'h1357_2468);
        bus_read(4'd11, v); check("R2 sense3", v, 32'hCAFE_0123);
        bus_write(4'd2, 32'h0000_2000);
        pins[13] = 1'b1;
        idle(4);
        bus_read(4'd3, v); check("R2 pin13 high", v, 32'h0000_2000);
    endtask

    task automatic test_mask();
        logic [31:0] v;
        do_reset();
        bus_write(4'd0, 32'h0000_0101);
        bus_read(4'd0, v); check("R4 set", v, 32'h0000_0101);
        bus_write(4'd0, 32'h0);
        bus_read(4'd1, v); check("R4 set zeros", v, 32'h0000_0101);
        bus_write(4'd1, 32'h0000_0001);
        bus_read(4'd0, v); check("R4 clear", v, 32'h0000_0100);
        bus_write(4'd1, 32'h0);
        bus_read(4'd1, v); check("R4 clear zeros", v, 32'h0000_0100);
    endtask

    task automatic test_modes();
        logic [31:0] v;
        do_reset();
        bus_write(4'd8, 32'h7654_3210);
        bus_write(4'd2, 32'h0000_00FF);
        idle(4);
        bus_read(4'd3, v); check("R3 low level only", v, 32'h08);
        bus_write(4'd3, 32'hFF);
        bus_read(4'd3, v); check("R5 level re-set after clear", v, 32'h08);
        pins[7:0] = 8'hFF;
        idle(4);
        bus_read(4'd3, v); check("R3 rise/high/both", v, 32'h1D);
        bus_write(4'd3, 32'hFF);
        bus_read(4'd3, v); check("R5 high stays", v, 32'h04);
        pins[7:0] = 8'h00;
        idle(4);
        bus_read(4'd3, v); check("R3 fall/low/both, reserved quiet", v, 32'h1E);
        check("R9 no mask no irq", {31'b0, irq_lo}, 32'h0);
    endtask

    task automatic test_latency();
        logic [31:0] v;
        do_reset();
        bus_write(4'd8, 32'h0000_0008);
        bus_write(4'd2, 32'h0000_0003);
        pins[1:0] = 2'b11;
        idle(1);
        bus_read(4'd3, v); check("R10 edge k", v, 32'h0);
        idle(1);
        bus_read(4'd3, v); check("R10 edge k+1 fast only", v, 32'h1);
        idle(1);
        bus_read(4'd3, v); check("R10 edge k+2 both", v, 32'h3);
    endtask

    task automatic test_accept();
        logic [31:0] v;
        do_reset();
        pins[8] = 1'b1;
        idle(4);
        bus_read(4'd3, v); check("R6 not accepted", v, 32'h0);
        bus_write(4'd2, 32'h0000_0100);
        idle(4);
        bus_read(4'd3, v); check("R6 old edge dropped", v, 32'h0);
        pins[8] = 1'b0;
        idle(2);
        pins[8] = 1'b1;
        idle(4);
        bus_read(4'd3, v); check("R6 accepted edge", v, 32'h100);
        bus_write(4'd3, 32'h0000_0001);
        bus_read(4'd3, v); check("R5 zero bits keep", v, 32'h100);
        bus_write(4'd3, 32'h0000_0100);
        bus_read(4'd3, v); check("R5 clear edge", v, 32'h0);
    endtask

    task automatic test_status();
        logic [31:0] v;
        do_reset();
        bus_write(4'd8,  32'h0000_0200);
        bus_write(4'd10, 32'h0000_0020);
        bus_write(4'd2,  32'h0002_0004);
        pins[2] = 1'b1; pins[17] = 1'b1;
        idle(4);
        bus_read(4'd3, v); check("R5 pending ignores mask", v, 32'h0002_0004);
        bus_read(4'd4, v); check("R7 masked none", v, 32'h0);
        bus_read(4'd5, v); check("R8 raw low", v, 32'h4);
        bus_read(4'd6, v); check("R8 raw high", v, 32'h2);
        check("R9 both low", {30'b0, irq_hi, irq_lo}, 32'h0);
        bus_write(4'd0, 32'h0000_0004);
        bus_read(4'd4, v); check("R7 masked low", v, 32'h4);
        check("R9 lo only", {30'b0, irq_hi, irq_lo}, 32'h1);
        bus_write(4'd0, 32'h0002_0000);
        check("R9 both", {30'b0, irq_hi, irq_lo}, 32'h3);
        bus_write(4'd1, 32'h0000_0004);
        bus_read(4'd4, v); check("R7 masked high", v, 32'h0002_0000);
        check("R9 hi only", {30'b0, irq_hi, irq_lo}, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_layout();
        test_mask();
        test_modes();
        test_latency();
        test_accept();
        test_status();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule